// File: doc/BRIEF.md
# Sticky Edge-Interrupt Register with Read-Clear

This block holds five sticky interrupt flags inside the link-side register file of a USB transceiver. Each flag watches one status input: host disconnect, VBUS valid, session valid, session end and ID. The inputs are first brought into the register clock domain. Each flag then latches when its input shows a rising or falling edge that software has enabled.

The link reads the flags through a single-cycle read strobe together with an address. When the address matches the register's address, the registered read data appears on the next cycle, and the flags clear in the same step. An edge that arrives in the very cycle of a read is not lost. It goes straight into the returned data and is not latched. A pulse marking entry into low-power mode, serial mode or car-kit mode empties the register. Such a clear takes priority over a flag that is being set in the same cycle.

Top module: `usb_irq_latch`

## Requirements
- R1: Returned data bits map as follows: bit 0 host disconnect, bit 1 VBUS valid, bit 2 session valid, bit 3 session end and bit 4 ID. Bits 7:5 always read 0.
- R2: After reset, all flags are 0, `rd_data` is 0x00 and `rd_valid` is 0.
- R3: A flag sets when its synchronized input rises while its rising enable is 1, or falls while its falling enable is 1. Transitions in a direction that is not enabled are ignored.
- R4: A flag whose rising enable and falling enable are both 0 never sets.
- R5: The host-disconnect flag (bit 0) can set only while `host_mode` is 1.
- R6: A read hit is `rd_strobe` = 1 with `rd_addr` = 0x14. One cycle after a read hit, `rd_valid` is 1 and `rd_data` carries the flags, and the flags are then 0. A strobe with any other address returns `rd_valid` = 0 and leaves the flags unchanged.
- R7: If a flag's set condition occurs in the same cycle as a read hit, the returned bit is 1 and the flag stays 0.
- R8: A one-cycle pulse on `lowpwr_enter`, `serial_enter` or `carkit_enter` clears all flags. When the pulse coincides with a set condition, the flag is still left at 0.
- R9: Without a read hit, a mode-entry pulse or a set condition, every flag holds its value.
- R10: Each status input passes through two synchronizer flops. A change driven before clock edge k is detected in the cycle after edge k+1 and latched at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_in | input | 5 | Raw status levels, bit order as in R1 |
| rise_en | input | 5 | Per-bit rising-edge enables |
| fall_en | input | 5 | Per-bit falling-edge enables |
| host_mode | input | 1 | High while the transceiver acts as host |
| rd_strobe | input | 1 | Single-cycle register read request |
| rd_addr | input | 6 | Register address of the read |
| lowpwr_enter | input | 1 | Pulse on low-power mode entry |
| serial_enter | input | 1 | Pulse on serial mode entry |
| carkit_enter | input | 1 | Pulse on car-kit mode entry |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High for the cycle that returns read data |

## Verification
The bench times a read so that it lands exactly in the cycle where an edge is being detected. A design that latched that edge would return it twice, and a design that ignored it would lose it. A second read must therefore come back empty. Mode-entry pulses are placed both after a flag has latched and on the same cycle as its set condition; a design that let the set win would leave a stale flag behind. The vector table mixes edge directions with partial enables, both-disabled bits and `host_mode` low, which catches inverted masks and an ungated host-disconnect bit. A wrong-address strobe is checked to neither return data nor clear the flags.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int IRQ_W     = 5;
    localparam int RD_W      = 8;
    localparam int RA_W      = 6;
    localparam logic [RA_W-1:0] IRQ_REG_ADDR = 6'h14;
    localparam int SYNC_DEPTH = 2;

    localparam int B_HOSTDISC = 0;
    localparam int B_VBUSOK   = 1;
    localparam int B_SESSOK   = 2;
    localparam int B_SESSEND  = 3;
    localparam int B_IDPIN    = 4;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stg[STAGES-1];

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int W        = 5,
    parameter int HOST_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         host_mode,
    output logic [W-1:0] set
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_t;

    edge_t st_d, st_q;
    logic [W-1:0] hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic armed;
        logic up;
        logic dn;
        assign armed = rise_en[g] | fall_en[g];
        assign up    = lvl[g] & ~st_q.prev[g];
        assign dn    = ~lvl[g] & st_q.prev[g];
        if (g == HOST_BIT) begin : g_host
            assign hit[g] = armed & host_mode &
                            ((up & rise_en[g]) | (dn & fall_en[g]));
        end else begin : g_plain
            assign hit[g] = armed & ((up & rise_en[g]) | (dn & fall_en[g]));
        end
    end

    assign set = hit;

endmodule

// File: rtl/irq_latch_core.sv
module irq_latch_core #(
    parameter int W    = 5,
    parameter int DW   = 8,
    parameter int AW   = 6,
    parameter logic [AW-1:0] ADDR = 6'h14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  set,
    input  logic          mode_clr,
    input  logic          rd_strobe,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  lat,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    typedef struct packed {
        logic [W-1:0]  lat;
        logic [DW-1:0] rdata;
        logic          rvld;
    } core_t;

    core_t st_d, st_q;
    logic  rd_hit;

    assign rd_hit = rd_strobe && (rd_addr == ADDR);

    always_comb begin
        st_d      = st_q;
        st_d.rvld = rd_hit;
        if (rd_hit) begin
            st_d.rdata = DW'(st_q.lat | set);
        end
        if (mode_clr) begin
            st_d.lat = '0;
        end else if (rd_hit) begin
            st_d.lat = '0;
        end else begin
            st_d.lat = st_q.lat | set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat      = st_q.lat;
    assign rd_data  = st_q.rdata;
    assign rd_valid = st_q.rvld;

endmodule

// File: rtl/usb_irq_latch.sv
module usb_irq_latch
    import usb_irq_pkg::*;
#(
    parameter int W      = IRQ_W,
    parameter int DW     = RD_W,
    parameter int AW     = RA_W,
    parameter logic [AW-1:0] ADDR = IRQ_REG_ADDR,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  status_in,
    input  logic [W-1:0]  rise_en,
    input  logic [W-1:0]  fall_en,
    input  logic          host_mode,
    input  logic          rd_strobe,
    input  logic [AW-1:0] rd_addr,
    input  logic          lowpwr_enter,
    input  logic          serial_enter,
    input  logic          carkit_enter,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    logic [W-1:0] lvl_w;
    logic [W-1:0] set_w;
    logic [W-1:0] lat_w;
    logic         mode_clr;

    assign mode_clr = lowpwr_enter | serial_enter | carkit_enter;

    irq_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (status_in),
        .dout (lvl_w)
    );

    irq_edge_det #(.W(W), .HOST_BIT(B_HOSTDISC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_w),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .host_mode(host_mode),
        .set      (set_w)
    );

    irq_latch_core #(.W(W), .DW(DW), .AW(AW), .ADDR(ADDR)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (set_w),
        .mode_clr (mode_clr),
        .rd_strobe(rd_strobe),
        .rd_addr  (rd_addr),
        .lat      (lat_w),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/usb_irq_latch_chk.sv
module usb_irq_latch_chk #(
    parameter int W  = 5,
    parameter int DW = 8,
    parameter int AW = 6,
    parameter logic [AW-1:0] ADDR = 6'h14
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  rise_en,
    input logic [W-1:0]  fall_en,
    input logic          host_mode,
    input logic          rd_strobe,
    input logic [AW-1:0] rd_addr,
    input logic          lowpwr_enter,
    input logic          serial_enter,
    input logic          carkit_enter,
    input logic [W-1:0]  lat_w,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid
);

    logic hit;
    logic clr;
    assign hit = rd_strobe && (rd_addr == ADDR);
    assign clr = lowpwr_enter | serial_enter | carkit_enter;

    // R1: reserved bits read zero
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:W] == '0);

    // R6: a read hit produces valid data next cycle
    p_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> rd_valid);

    // R6: valid data only after a read hit
    p_valid_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(hit));

    // R6: returned data contains at least every latched flag
    p_read_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ((rd_data[W-1:0] & $past(lat_w)) == $past(lat_w)));

    // R6, R7: flags are empty after a read hit
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (lat_w == '0));

    // R8: mode entry empties the flags
    p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lat_w == '0));

    // R4: a bit with both enables off never sets
    p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat_w & ~$past(lat_w) & ~$past(rise_en | fall_en)) == '0));

    // R5: host-disconnect flag rises only in host mode
    p_host_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_w[0]) |-> $past(host_mode));

    // R9: flags never drop without a read hit or a mode clear
    p_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !clr) |=> ((lat_w & $past(lat_w)) == $past(lat_w)));

endmodule

bind usb_irq_latch usb_irq_latch_chk #(.W(W), .DW(DW), .AW(AW), .ADDR(ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_en     (rise_en),
    .fall_en     (fall_en),
    .host_mode   (host_mode),
    .rd_strobe   (rd_strobe),
    .rd_addr     (rd_addr),
    .lowpwr_enter(lowpwr_enter),
    .serial_enter(serial_enter),
    .carkit_enter(carkit_enter),
    .lat_w       (lat_w),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
);

// File: tb/usb_irq_latch_test.sv
`timescale 1ns/1ps
module usb_irq_latch_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] status_in = '0;
    logic [4:0] rise_en = '0;
    logic [4:0] fall_en = '0;
    logic       host_mode = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [5:0] rd_addr = '0;
    logic       lowpwr_enter = 1'b0;
    logic       serial_enter = 1'b0;
    logic       carkit_enter = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    usb_irq_latch uut (
        .clk(clk), .rst_n(rst_n), .status_in(status_in), .rise_en(rise_en),
        .fall_en(fall_en), .host_mode(host_mode), .rd_strobe(rd_strobe),
        .rd_addr(rd_addr), .lowpwr_enter(lowpwr_enter), .serial_enter(serial_enter),
        .carkit_enter(carkit_enter), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct packed {
        logic [4:0] st;
        logic [4:0] re;
        logic [4:0] fe;
        logic       host;
        logic [7:0] exp;
    } vec_t;

    // R3 R4 R5: edge directions, masks and host gating
    localparam vec_t VEC [10] = '{
        '{st:5'h1F, re:5'h1F, fe:5'h00, host:1'b1, exp:8'h1F},
        '{st:5'h00, re:5'h1F, fe:5'h00, host:1'b1, exp:8'h00},
        '{st:5'h1F, re:5'h00, fe:5'h1F, host:1'b1, exp:8'h00},
        '{st:5'h00, re:5'h00, fe:5'h1F, host:1'b1, exp:8'h1F},
        '{st:5'h0A, re:5'h02, fe:5'h00, host:1'b1, exp:8'h02},
        '{st:5'h15, re:5'h1F, fe:5'h08, host:1'b0, exp:8'h1C},
        '{st:5'h14, re:5'h1F, fe:5'h1F, host:1'b0, exp:8'h00},
        '{st:5'h15, re:5'h01, fe:5'h00, host:1'b1, exp:8'h01},
        '{st:5'h00, re:5'h1F, fe:5'h1F, host:1'b1, exp:8'h15},
        '{st:5'h1F, re:5'h00, fe:5'h00, host:1'b1, exp:8'h00}
    };

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one-cycle strobe; returns sampled data after the capturing edge
    task automatic do_read(input logic [5:0] a, output logic [7:0] d, output logic v);
        rd_strobe = 1'b1;
        rd_addr   = a;
        @(negedge clk);
        rd_strobe = 1'b0;
        rd_addr   = '0;
        d = rd_data;
        v = rd_valid;
    endtask

    initial begin
        logic [7:0] d;
        logic       v;
        tick(2);
        chk("R2 reset data", rd_data, 8'h00);
        chk("R2 reset valid", {7'b0, rd_valid}, 8'h00);
        rst_n = 1'b1;
        tick(2);
        do_read(6'h14, d, v);
        chk("R2 first read empty", d, 8'h00);

        // vector table
        for (int k = 0; k < 10; k++) begin
            status_in = VEC[k].st;
            rise_en   = VEC[k].re;
            fall_en   = VEC[k].fe;
            host_mode = VEC[k].host;
            tick(3);
            do_read(6'h14, d, v);
            chk($sformatf("R3 R1 vector %0d data", k), d, VEC[k].exp);
            chk($sformatf("R6 vector %0d valid", k), {7'b0, v}, 8'h01);
        end
        // status now 1F, enables off; arm all directions
        rise_en = 5'h1F; fall_en = 5'h1F; host_mode = 1'b1;
        tick(2);

        // R6: read clears; second read empty
        status_in = 5'h1D;              // bit1 falls
        tick(3);
        do_read(6'h14, d, v);
        chk("R6 read returns flag", d, 8'h02);
        do_read(6'h14, d, v);
        chk("R6 read clears", d, 8'h00);

        // R6: wrong address neither returns nor clears
        status_in = 5'h1F;              // bit1 rises
        tick(3);
        do_read(6'h15, d, v);
        chk("R6 wrong addr no valid", {7'b0, v}, 8'h00);
        do_read(6'h14, d, v);
        chk("R6 wrong addr kept flag", d, 8'h02);

        // R7: collision of set and read
        status_in = 5'h17;              // bit3 falls
        tick(2);
        do_read(6'h14, d, v);
        chk("R7 collision returned", d, 8'h08);
        do_read(6'h14, d, v);
        chk("R7 collision not latched", d, 8'h00);

        // R10: one cycle early the edge is not yet visible
        status_in = 5'h1F;              // bit3 rises
        tick(1);
        do_read(6'h14, d, v);
        chk("R10 not yet synchronized", d, 8'h00);
        do_read(6'h14, d, v);
        chk("R10 detected after two flops", d, 8'h08);

        // R8: each mode-entry source clears a latched flag
        for (int m = 0; m < 3; m++) begin
            status_in = status_in ^ 5'h10;   // bit4 toggles
            tick(3);
            lowpwr_enter = (m == 0);
            serial_enter = (m == 1);
            carkit_enter = (m == 2);
            tick(1);
            lowpwr_enter = 1'b0; serial_enter = 1'b0; carkit_enter = 1'b0;
            do_read(6'h14, d, v);
            chk($sformatf("R8 mode clear source %0d", m), d, 8'h00);
        end

        // R8: clear wins over same-cycle set
        status_in = status_in ^ 5'h04;       // bit2 toggles
        tick(2);
        serial_enter = 1'b1;
        tick(1);
        serial_enter = 1'b0;
        do_read(6'h14, d, v);
        chk("R8 clear beats set", d, 8'h00);

        // R9: flag holds over idle cycles
        status_in = status_in ^ 5'h01;       // bit0 toggles, host mode on
        tick(3);
        tick(20);
        do_read(6'h14, d, v);
        chk("R9 flag held", d, 8'h01);

        // R5: host mode off blocks bit0 even with enables on
        host_mode = 1'b0;
        status_in = status_in ^ 5'h01;
        tick(3);
        do_read(6'h14, d, v);
        chk("R5 host gate", d, 8'h00);

        finish_run();
    end

endmodule